// File: doc/BRIEF.md
# I2C Slave General-Call Decoder

This block sits behind the byte-level receiver of an I2C slave. It watches the framing events (start or repeated start, stop) and the stream of received bytes, and for every byte it returns an acknowledge decision. When general-call recognition is switched on, an all-zero address byte is claimed. The byte after it then selects one of three actions. It can load a new slave address from the next byte. It can load a new slave address and then put the node through a reset. Or it can capture the address of a hardware master that announces itself.

The programmed slave address is held in a register that starts from a parameter value. A reset request goes out as a single-cycle pulse on the stop that closes a load-and-reset sequence. While the reset runs, a bus-release output tells the pad logic to leave SDA and SCL undriven. The captured hardware-master address comes with a one-cycle strobe.

Received bytes arrive on a valid/ready stream. A byte is transferred on a clock edge where `rx_valid` and `rx_ready` are both high. The sender must hold `rx_valid` and `rx_data` steady until that edge. `rx_ready` is low only during the reset hold window. The decision comes back one cycle after each transfer as an `ack_valid` pulse qualified by `ack`. This output cannot be stalled. Its `ack` is 1 only for bytes this decoder accepts as part of a general call. Matching the node's own address is left to neighbouring logic.

Top module: `gc_decoder`

## Requirements
- R1: Out of reset, `slave_addr` equals the parameter `DEF_ADDR` (default 7'h2A), `ack_valid`, `reset_req`, `hw_strobe` and `bus_release` are 0, and `rx_ready` is 1.
- R2: The first byte after a start that equals 8'h00 is answered with `ack`=1 when `cfg_gc_en` is 1, and with `ack`=0 when it is 0. In the disabled case, every later byte up to the next start or stop is also answered with `ack`=0.
- R3: A first byte after a start that is not 8'h00 gets `ack`=0, and so does every further byte of that transfer.
- R4: In a general call, a second byte of 8'h04 gets `ack`=1, and the third byte gets `ack`=1. `slave_addr` takes bits [7:1] of the third byte in the cycle the third byte's `ack_valid` shows, and no `reset_req` follows.
- R5: A second byte of 8'h06 acts as in R4, except that the stop after the third byte makes `reset_req` pulse for exactly one cycle. `bus_release` is 1 from that same cycle for `RST_HOLD` cycles (default 16), and `rx_ready` is 0 for exactly those cycles.
- R6: A second byte with bit 0 set gets `ack`=1. `hw_addr` takes its bits [7:1], and `hw_strobe` pulses for one cycle alongside that byte's `ack_valid`.
- R7: A second byte with bit 0 clear that is neither 8'h04 nor 8'h06 (including 8'h00) gets `ack`=0. All later bytes of the transfer get `ack`=0, and `slave_addr` keeps its value.
- R8: Bytes after the third byte of an address load, and bytes after a hardware-master byte, get `ack`=0 and leave `slave_addr` unchanged.
- R9: A stop or repeated start before the sequence completes returns the decoder to the start of a transfer, with `slave_addr` unchanged. A byte after a stop and before any start gets `ack`=0. A repeated start in place of the closing stop of an 8'h06 sequence cancels the reset, but keeps the new address.
- R10: `ack_valid` is high for exactly one cycle, the cycle after each transfer and at no other time. A byte presented while `rx_ready` is 0 is held, and it is answered after the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gc_en | input | 1 | Enables recognition of the all-zero address |
| ev_start | input | 1 | One-cycle pulse: start or repeated start seen |
| ev_stop | input | 1 | One-cycle pulse: stop seen |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Decoder can take a byte (low during reset hold) |
| rx_data | input | 8 | Received byte, MSB first as sent on the bus |
| ack_valid | output | 1 | One-cycle pulse: decision for the last transferred byte |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledged by this decoder |
| slave_addr | output | 7 | Programmed slave address |
| reset_req | output | 1 | One-cycle request to reset the node |
| bus_release | output | 1 | Keep SDA and SCL undriven while high |
| hw_addr | output | 7 | Last captured hardware-master address |
| hw_strobe | output | 1 | One-cycle pulse: `hw_addr` was just updated |

## Verification
Almost every internal state error shows up on the very next byte. A decoder stuck in the wrong phase gives a wrong `ack` in the cycle after that byte's transfer. A lost reset flag shows up as a missing or spurious `reset_req` in the cycle right after the stop. A miscounted hold window shows as `bus_release` or `rx_ready` switching one cycle early or late at its boundary. The bench compares every byte's answer, the address registers and these window edges against a transfer-level model, under both directed and random traffic.

// File: rtl/gc_decoder_pkg.sv
package gc_decoder_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_NEWADR,
    ST_DRAIN,
    ST_ARMED
  } gc_state_e;

  typedef enum logic [1:0] {
    CMD_BAD,
    CMD_LOAD,
    CMD_LOAD_RST,
    CMD_HWMASTER
  } gc_cmd_e;

  localparam logic [7:0] GC_ADDR_BYTE  = 8'h00;
  localparam logic [7:0] CODE_LOAD     = 8'h04;
  localparam logic [7:0] CODE_LOAD_RST = 8'h06;
endpackage

// File: rtl/gc_cmd_decode.sv
module gc_cmd_decode
  import gc_decoder_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic [BW-1:0] code,
  output gc_cmd_e       kind
);
  always_comb begin
    if (code[0])
      kind = CMD_HWMASTER;
    else if (code == BW'(CODE_LOAD_RST))
      kind = CMD_LOAD_RST;
    else if (code == BW'(CODE_LOAD))
      kind = CMD_LOAD;
    else
      kind = CMD_BAD;
  end
endmodule

// File: rtl/gc_hold_timer.sv
module gc_hold_timer #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CW'(HOLD - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R5: the window only closes once the count has run out
  assert_hold_full_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == '0));
endmodule

// File: rtl/gc_addr_store.sv
module gc_addr_store #(
  parameter int             AW   = 7,
  parameter logic [AW-1:0]  INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= INIT;
    else if (load) q <= din;
  end
endmodule

// File: rtl/gc_decoder.sv
module gc_decoder
  import gc_decoder_pkg::*;
#(
  parameter int             AW       = 7,
  parameter logic [AW-1:0]  DEF_ADDR = 7'h2A,
  parameter int             RST_HOLD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_gc_en,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [AW:0]   rx_data,
  output logic          ack_valid,
  output logic          ack,
  output logic [AW-1:0] slave_addr,
  output logic          reset_req,
  output logic          bus_release,
  output logic [AW-1:0] hw_addr,
  output logic          hw_strobe
);
  localparam int BW = AW + 1;

  gc_state_e st, st_d;
  gc_cmd_e   cmd;
  logic      rst_pend, pend_d;
  logic      xfer, ack_d, addr_load, hw_take, fire;
  logic      hold_busy;

  gc_cmd_decode #(.BW(BW)) u_cmd (
    .code (rx_data),
    .kind (cmd)
  );

  gc_hold_timer #(.HOLD(RST_HOLD)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .busy  (hold_busy)
  );

  gc_addr_store #(.AW(AW), .INIT(DEF_ADDR)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load),
    .din   (rx_data[AW:1]),
    .q     (slave_addr)
  );

  assign rx_ready    = !hold_busy;
  assign bus_release = hold_busy;
  assign xfer        = rx_valid && rx_ready;

  always_comb begin
    st_d      = st;
    pend_d    = rst_pend;
    ack_d     = 1'b0;
    addr_load = 1'b0;
    hw_take   = 1'b0;
    fire      = 1'b0;
    if (!hold_busy && ev_stop) begin
      st_d = ST_IDLE;
      fire = (st == ST_ARMED);
    end else if (!hold_busy && ev_start) begin
      st_d = ST_ADDR;
    end else if (xfer) begin
      case (st)
        ST_ADDR: begin
          if (rx_data == BW'(GC_ADDR_BYTE) && cfg_gc_en) begin
            ack_d = 1'b1;
            st_d  = ST_CMD;
          end else begin
            st_d  = ST_DRAIN;
          end
        end
        ST_CMD: begin
          case (cmd)
            CMD_HWMASTER: begin
              ack_d   = 1'b1;
              hw_take = 1'b1;
              st_d    = ST_DRAIN;
            end
            CMD_LOAD: begin
              ack_d  = 1'b1;
              pend_d = 1'b0;
              st_d   = ST_NEWADR;
            end
            CMD_LOAD_RST: begin
              ack_d  = 1'b1;
              pend_d = 1'b1;
              st_d   = ST_NEWADR;
            end
            default: st_d = ST_DRAIN;
          endcase
        end
        ST_NEWADR: begin
          ack_d     = 1'b1;
          addr_load = 1'b1;
          st_d      = rst_pend ? ST_ARMED : ST_DRAIN;
        end
        default: st_d = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rst_pend  <= 1'b0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      reset_req <= 1'b0;
      hw_strobe <= 1'b0;
      hw_addr   <= '0;
    end else begin
      st        <= st_d;
      rst_pend  <= pend_d;
      ack_valid <= xfer;
      ack       <= ack_d;
      reset_req <= fire;
      hw_strobe <= hw_take;
      if (hw_take) hw_addr <= rx_data[AW:1];
    end
  end

  // R10: an answer appears only in the cycle after a transfer
  assert_ack_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid && rx_ready));

  // R5: the reset request coincides with the start of the release window
  assert_release_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> bus_release);

  // R5: the reset request lasts one cycle
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R8: the stored address only moves together with an acknowledged byte
  assert_addr_moves_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_addr != $past(slave_addr)) |-> (ack_valid && ack));

  // R6: the capture strobe belongs to an acknowledged byte
  assert_hw_strobe_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_strobe |-> (ack_valid && ack));

  // R2: with recognition off, the address byte is refused
  assert_gc_off_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && st == ST_ADDR && !cfg_gc_en && !ev_start && !ev_stop) |=> (ack_valid && !ack));
endmodule

// File: tb/sim_gc_decoder.sv
module sim_gc_decoder;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_gc_en = 1'b1;
  logic       ev_start = 1'b0, ev_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, ack_valid, ack, reset_req, bus_release, hw_strobe;
  logic [6:0] slave_addr, hw_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st = 0;          // 0 idle 1 addr 2 cmd 3 newadr 4 drain 5 armed
  bit m_rst = 0;
  logic [6:0] m_addr = 7'h2A, m_hw = 7'h00;

  always #2 clk = ~clk;

  gc_decoder #(.RST_HOLD(HOLD)) u0 (
    .clk, .rst_n, .cfg_gc_en, .ev_start, .ev_stop, .rx_valid, .rx_ready, .rx_data,
    .ack_valid, .ack, .slave_addr, .reset_req, .bus_release, .hw_addr, .hw_strobe
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b, output bit ea, output bit es);
    ea = 0; es = 0;
    case (m_st)
      1: if (b == 8'h00 && cfg_gc_en) begin ea = 1; m_st = 2; end else m_st = 4;
      2: if (b[0]) begin ea = 1; es = 1; m_hw = b[7:1]; m_st = 4; end
         else if (b == 8'h06) begin ea = 1; m_rst = 1; m_st = 3; end
         else if (b == 8'h04) begin ea = 1; m_rst = 0; m_st = 3; end
         else m_st = 4;
      3: begin ea = 1; m_addr = b[7:1]; m_st = m_rst ? 5 : 4; end
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    bit ea, es;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    model_byte(b, ea, es);
    @(negedge clk);
    rx_valid = 1'b0;
    chk(ack_valid == 1'b1, {tag, " ack_valid"}, ack_valid, 1);
    chk(ack == ea, {tag, " ack"}, ack, ea);
    chk(hw_strobe == es, {tag, " hw_strobe"}, hw_strobe, es);
    chk(hw_addr == m_hw, {tag, " hw_addr"}, hw_addr, m_hw);
    chk(slave_addr == m_addr, {tag, " slave_addr"}, slave_addr, m_addr);
  endtask

  task automatic do_start();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
    m_st = 1;
  endtask

  task automatic do_stop(input string tag);
    bit fire;
    fire = (m_st == 5);
    m_st = 0;
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
    chk(reset_req == fire, {tag, " reset_req"}, reset_req, fire);
    chk(bus_release == fire, {tag, " bus_release"}, bus_release, fire);
    if (fire) begin
      chk(rx_ready == 1'b0, {tag, " R5 rx_ready in hold"}, rx_ready, 0);
      @(negedge clk);
      chk(reset_req == 1'b0, {tag, " R5 reset_req one cycle"}, reset_req, 0);
      repeat (HOLD - 2) @(negedge clk);
      chk(bus_release == 1'b1, {tag, " R5 last hold cycle"}, bus_release, 1);
      @(negedge clk);
      chk(bus_release == 1'b0 && rx_ready == 1'b1, {tag, " R5 hold end"}, bus_release, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slave_addr == 7'h2A && ack_valid == 0 && reset_req == 0 && hw_strobe == 0,
        "R1 reset outputs", slave_addr, 7'h2A);
    chk(bus_release == 0 && rx_ready == 1, "R1 ready out of reset", rx_ready, 1);

    // R4 load without reset, then R8 trailing byte
    do_start(); send(8'h00, "R4 gc addr"); send(8'h04, "R4 cmd");
    send(8'hA6, "R4 new addr"); send(8'h55, "R8 trailing"); do_stop("R4 stop");
    // R2 disabled general call
    cfg_gc_en = 1'b0;
    do_start(); send(8'h00, "R2 gc off"); send(8'h04, "R2 gc off follow"); do_stop("R2 stop");
    cfg_gc_en = 1'b1;
    // R3 non-zero address
    do_start(); send(8'hA0, "R3 other addr"); send(8'h04, "R3 follow"); do_stop("R3 stop");
    // R5 load with reset
    do_start(); send(8'h00, "R5 gc addr"); send(8'h06, "R5 cmd");
    send(8'h5C, "R5 new addr"); send(8'h12, "R8 after load"); do_stop("R5 stop");
    // R6 hardware master
    do_start(); send(8'h00, "R6 gc addr"); send(8'h8F, "R6 hw byte"); send(8'h33, "R8 after hw");
    do_stop("R6 stop");
    // R7 illegal and unknown codes
    do_start(); send(8'h00, "R7 gc addr"); send(8'h00, "R7 zero code"); send(8'h88, "R7 follow");
    do_start(); send(8'h00, "R7 gc addr"); send(8'h02, "R7 unknown code"); do_stop("R7 stop");
    // R9 mid-sequence stop and repeated start
    do_start(); send(8'h00, "R9 gc addr"); send(8'h06, "R9 cmd"); do_stop("R9 early stop");
    send(8'h40, "R9 byte without start");
    do_start(); send(8'h00, "R9 gc addr"); send(8'h06, "R9 cmd"); send(8'h3A, "R9 addr");
    do_start(); send(8'h11, "R9 restart cancels"); do_stop("R9 no reset");
    // R10 byte held across the reset window
    do_start(); send(8'h00, "R10 gc addr"); send(8'h06, "R10 cmd"); send(8'h44, "R10 addr");
    m_st = 0;
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0; rx_valid = 1'b1; rx_data = 8'h00;
    chk(reset_req == 1 && rx_ready == 0, "R10 hold begins", rx_ready, 0);
    for (int i = 0; i < HOLD - 1; i++) begin
      @(negedge clk);
      chk(ack_valid == 0, "R10 no answer while stalled", ack_valid, 0);
    end
    @(negedge clk);
    chk(rx_ready == 1 && ack_valid == 0, "R10 ready returns", rx_ready, 1);
    @(negedge clk);
    rx_valid = 1'b0;
    chk(ack_valid == 1 && ack == 0, "R10 held byte answered", ack, 0);
    @(negedge clk);
    chk(ack_valid == 0, "R10 single answer", ack_valid, 0);

    // random traffic
    for (int t = 0; t < 150; t++) begin
      int r;
      cfg_gc_en = ($urandom % 5) != 0;
      do_start();
      send(($urandom % 3 == 0) ? 8'($urandom) : 8'h00, "R2 rand addr");
      r = $urandom % 6;
      case (r)
        0: send(8'h04, "R4 rand cmd");
        1: send(8'h06, "R5 rand cmd");
        2: send(8'($urandom) | 8'h01, "R6 rand cmd");
        3: send(8'h00, "R7 rand cmd");
        4: send(8'($urandom) & 8'hFE, "R7 rand even");
        default: send(8'($urandom), "R7 rand any");
      endcase
      for (int k = 0; k < int'($urandom % 4); k++) send(8'($urandom), "R8 rand data");
      if ($urandom % 5 != 0) do_stop("R9 rand stop");
    end
    do_stop("R9 final stop");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule